// File: doc/BRIEF.md
# Clock Pulse Skipper Throttle

This block produces a per-cycle enable for a downstream clock gate. When thermal throttling is requested it suppresses a set share of the input clock pulses, which lowers the effective frequency of a processor or graphics clock domain. The share of pulses to drop is either a percentage given directly in processor mode, or one of four coded levels in graphics mode. The four levels stand for no skipping, half, three quarters and 85 percent.

Skipping runs over a fixed window of cycles, 100 by default. A fractional accumulator spreads the dropped pulses as evenly as possible across each window, so they do not come in bursts. A new request is picked up only at a window edge. The block drives only the enable pattern. The gating cell and any clock source control sit outside it.

Top module: `pulse_skip_throttle`

## Requirements
- R1: While reset is asserted, `pulse_en` is 1 and `throt_active` is 0. The first window after reset runs with a depth of 0.
- R2: With an applied depth of D (0 to 100), exactly D of the 100 cycles of a window have `pulse_en` low.
- R3: In processor mode (`gpu_mode`=0), a `cpu_pct` value above 100 is treated as 100, so every pulse of the window is skipped.
- R4: In graphics mode (`gpu_mode`=1), the value of `cpu_pct` has no effect. `gpu_lvl` selects the depth: 2'd0 gives 0, 2'd1 gives 50, 2'd2 gives 75 and 2'd3 gives 85.
- R5: Skips are spread evenly. Count the cycles of a window from k=0. Cycle k is skipped exactly when floor((k+1)·D/100) > floor(k·D/100).
- R6: The request inputs are sampled only in the last cycle of a window, and they take effect from the next window. A change in the middle of a window leaves the rest of that window unchanged.
- R7: When the applied depth is 0, every pulse passes and `throt_active` is 0. When the applied depth is nonzero, `throt_active` is 1 for the whole window.
- R8: When `throt_req` is 0, the requested depth is 0 whatever the mode, percentage and level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock whose pulses are being thinned |
| rst_n | input | 1 | Asynchronous reset, active low |
| throt_req | input | 1 | Throttle request; 0 asks for no skipping |
| gpu_mode | input | 1 | 0: depth from `cpu_pct`; 1: depth from `gpu_lvl` |
| cpu_pct | input | PCT_W (7) | Skip percentage in processor mode; values above 100 are clamped |
| gpu_lvl | input | 2 | Coded skip level in graphics mode |
| pulse_en | output | 1 | 1 = let this clock pulse through, 0 = suppress it |
| throt_active | output | 1 | Nonzero depth applied in the current window |

## Verification
The bench steps through every processor percentage from 0 to 100, one per window. For each one it checks every cycle of the window against the floor-difference formula, which separates even spreading from bunched or shifted skipping, and it also checks the total skip count. It then runs the four graphics levels, with a misleading `cpu_pct` present, to show the level decode and that the percentage is ignored. The out-of-range values 101 and 127 expose a missing clamp. A dropped request exposes a depth that does not depend on `throt_req`. Each new setting is applied 30 cycles into the window before it takes effect, so every window after that point also checks that a change in mid-window is not picked up early.

// File: rtl/pskip_pkg.sv
package pskip_pkg;
   localparam int unsigned FULL_PCT = 100;
   localparam int unsigned MIN_PCT_W = 7;

   typedef enum logic [1:0] {
      GL_OFF   = 2'd0,
      GL_LIGHT = 2'd1,
      GL_MID   = 2'd2,
      GL_DEEP  = 2'd3
   } gpu_lvl_e;
endpackage

// File: rtl/pskip_depth_decode.sv
module pskip_depth_decode
   import pskip_pkg::*;
#(
   parameter int unsigned WIN   = 100,
   parameter int unsigned PCT_W = 7,
   parameter int unsigned LVL1  = 50,
   parameter int unsigned LVL2  = 75,
   parameter int unsigned LVL3  = 85
) (
   input  logic                         throt_req,
   input  logic                         gpu_mode,
   input  logic [PCT_W-1:0]             cpu_pct,
   input  logic [1:0]                   gpu_lvl,
   output logic [$clog2(WIN+1)-1:0]     depth_req
);
   localparam int unsigned DW = $clog2(WIN+1);
   localparam int unsigned SW = PCT_W + DW;

   logic [PCT_W-1:0] pct_lim;

   always_comb begin
      pct_lim = '0;
      if (gpu_mode) begin
         case (gpu_lvl_e'(gpu_lvl))
            GL_LIGHT: pct_lim = PCT_W'(LVL1);
            GL_MID:   pct_lim = PCT_W'(LVL2);
            GL_DEEP:  pct_lim = PCT_W'(LVL3);
            default:  pct_lim = '0;
         endcase
      end else if (cpu_pct > PCT_W'(FULL_PCT)) begin
         pct_lim = PCT_W'(FULL_PCT);
      end else begin
         pct_lim = cpu_pct;
      end
      if (!throt_req) pct_lim = '0;
   end

   generate
      if (WIN == FULL_PCT) begin : g_direct
         assign depth_req = DW'(pct_lim);
      end else begin : g_scaled
         logic [SW-1:0] prod;
         assign prod      = SW'(pct_lim) * SW'(WIN);
         assign depth_req = DW'(prod / SW'(FULL_PCT));
      end
   endgenerate
endmodule

// File: rtl/pskip_window_seq.sv
module pskip_window_seq #(
   parameter int unsigned WIN = 100
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(WIN+1)-1:0]   depth_req,
   output logic                       win_last,
   output logic [$clog2(WIN+1)-1:0]   depth_q
);
   localparam int unsigned CW = $clog2(WIN);

   logic [CW-1:0] pos_q;

   assign win_last = (pos_q == CW'(WIN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         depth_q <= '0;
      end else begin
         pos_q <= win_last ? '0 : pos_q + CW'(1);
         if (win_last) depth_q <= depth_req;
      end
   end
endmodule

// File: rtl/pskip_accum.sv
module pskip_accum #(
   parameter int unsigned WIN = 100
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       win_last,
   input  logic [$clog2(WIN+1)-1:0]   depth_q,
   output logic                       skip_now,
   output logic [$clog2(WIN)-1:0]     acc_q
);
   localparam int unsigned AW = $clog2(WIN);

   logic [AW:0] sum;
   logic [AW:0] wrapped;

   assign sum      = {1'b0, acc_q} + (AW+1)'(depth_q);
   assign skip_now = (sum >= (AW+1)'(WIN));
   assign wrapped  = skip_now ? sum - (AW+1)'(WIN) : sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        acc_q <= '0;
      else if (win_last) acc_q <= '0;
      else               acc_q <= AW'(wrapped);
   end
endmodule

// File: rtl/pulse_skip_throttle.sv
module pulse_skip_throttle
   import pskip_pkg::*;
#(
   parameter int unsigned WIN     = 100,
   parameter int unsigned PCT_W   = 7,
   parameter int unsigned LVL1    = 50,
   parameter int unsigned LVL2    = 75,
   parameter int unsigned LVL3    = 85,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             throt_req,
   input  logic             gpu_mode,
   input  logic [PCT_W-1:0] cpu_pct,
   input  logic [1:0]       gpu_lvl,
   output logic             pulse_en,
   output logic             throt_active
);
   localparam int unsigned DW = $clog2(WIN+1);
   localparam int unsigned AW = $clog2(WIN);

   generate
      if (WIN < 2) begin : g_bad_win
         $error("pulse_skip_throttle: WIN must be at least 2");
      end
      if (PCT_W < MIN_PCT_W) begin : g_bad_pct
         $error("pulse_skip_throttle: PCT_W too narrow for a full percentage");
      end
      if (LVL1 > FULL_PCT || LVL2 > FULL_PCT || LVL3 > FULL_PCT) begin : g_bad_lvl
         $error("pulse_skip_throttle: level percentages must not exceed 100");
      end
   endgenerate

   logic [DW-1:0] depth_req;
   logic [DW-1:0] depth_q;
   logic          win_last;
   logic          skip_now;
   logic [AW-1:0] acc_q;
   logic          pass_c;
   logic          act_c;

   pskip_depth_decode #(
      .WIN(WIN), .PCT_W(PCT_W), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
   ) u_decode (
      .throt_req (throt_req),
      .gpu_mode  (gpu_mode),
      .cpu_pct   (cpu_pct),
      .gpu_lvl   (gpu_lvl),
      .depth_req (depth_req)
   );

   pskip_window_seq #(.WIN(WIN)) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .depth_req (depth_req),
      .win_last  (win_last),
      .depth_q   (depth_q)
   );

   pskip_accum #(.WIN(WIN)) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_last (win_last),
      .depth_q  (depth_q),
      .skip_now (skip_now),
      .acc_q    (acc_q)
   );

   assign pass_c = ~skip_now;
   assign act_c  = (depth_q != '0);

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pulse_en     <= 1'b1;
               throt_active <= 1'b0;
            end else begin
               pulse_en     <= pass_c;
               throt_active <= act_c;
            end
         end
      end else begin : g_out_comb
         assign pulse_en     = pass_c;
         assign throt_active = act_c;
      end
   endgenerate
endmodule

// File: rtl/pulse_skip_throttle_chk.sv
module pulse_skip_throttle_chk #(
   parameter int unsigned WIN = 100
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       pulse_en,
   input  logic                       throt_active,
   input  logic                       win_last,
   input  logic                       skip_now,
   input  logic [$clog2(WIN+1)-1:0]   depth_q,
   input  logic [$clog2(WIN)-1:0]     acc_q
);
   localparam int unsigned DW = $clog2(WIN+1);

   logic [DW-1:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seen_q <= '0;
      else if (win_last) seen_q <= '0;
      else               seen_q <= seen_q + DW'(skip_now);
   end

   // R7
   idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !throt_active |-> pulse_en);

   // R6
   depth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_last |=> $stable(depth_q));

   // R2
   window_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_last |-> ((seen_q + DW'(skip_now)) == depth_q));

   // R5
   acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < ($clog2(WIN))'(WIN));

   // R3
   full_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_q == DW'(WIN)) |-> skip_now);
endmodule

bind pulse_skip_throttle pulse_skip_throttle_chk #(.WIN(WIN)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pulse_en     (pulse_en),
   .throt_active (throt_active),
   .win_last     (win_last),
   .skip_now     (skip_now),
   .depth_q      (depth_q),
   .acc_q        (acc_q)
);

// File: tb/test_pulse_skip_throttle.sv
`timescale 1ns/1ps
module test_pulse_skip_throttle;
   localparam int NCFG = 110;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       throt_req = 1'b0;
   logic       gpu_mode = 1'b0;
   logic [6:0] cpu_pct = '0;
   logic [1:0] gpu_lvl = '0;
   logic       pulse_en;
   logic       throt_active;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pulse_skip_throttle i_pulse_skip_throttle (
      .clk(clk), .rst_n(rst_n), .throt_req(throt_req), .gpu_mode(gpu_mode),
      .cpu_pct(cpu_pct), .gpu_lvl(gpu_lvl),
      .pulse_en(pulse_en), .throt_active(throt_active)
   );

   // configuration i: 0..100 processor percent, then special cases
   task automatic apply(input int i);
      throt_req = 1'b1; gpu_mode = 1'b0; gpu_lvl = 2'd0; cpu_pct = 7'd0;
      if (i <= 100) cpu_pct = 7'(i);
      else if (i <= 104) begin gpu_mode = 1'b1; gpu_lvl = 2'(i - 101); cpu_pct = 7'd33; end
      else if (i == 105) cpu_pct = 7'd101;
      else if (i == 106) cpu_pct = 7'd127;
      else if (i == 107) begin throt_req = 1'b0; cpu_pct = 7'd60; end
      else if (i == 108) begin gpu_mode = 1'b1; gpu_lvl = 2'd2; cpu_pct = 7'd10; end
      else begin throt_req = 1'b0; gpu_mode = 1'b1; gpu_lvl = 2'd3; end
   endtask

   function automatic int exp_depth(input int i);
      if (i <= 100) return i;
      case (i)
         101: return 0;
         102: return 50;
         103: return 75;
         104: return 85;
         105, 106: return 100;
         108: return 75;
         default: return 0;
      endcase
   endfunction

   function automatic string req_tag(input int i);
      if (i < 0) return "R1";
      if (i == 0) return "R7";
      if (i <= 100) return "R5";
      if (i <= 104 || i == 108) return "R4";
      if (i <= 106) return "R3";
      return "R8";
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // window w runs configuration w-1 (window 0 runs reset depth 0)
   task automatic run_window(input int w);
      int    d;
      int    cfg;
      int    skips;
      string t;
      cfg   = w - 1;
      d     = (w == 0) ? 0 : exp_depth(cfg);
      skips = 0;
      for (int k = 0; k < 100; k++) begin
         bit sk;
         #1;
         sk = (((k + 1) * d) / 100) > ((k * d) / 100);
         t  = (k > 30) ? {"R6 ", req_tag(cfg)} : req_tag(cfg);
         check(pulse_en == !sk, {t, " pulse_en"}, int'(pulse_en), int'(!sk));
         check(throt_active == (d != 0), {(d == 0) ? "R7 " : "", t, " throt_active"},
               int'(throt_active), int'(d != 0));
         if (!pulse_en) skips++;
         if (k == 30 && w < NCFG) apply(w);
         @(posedge clk);
         @(negedge clk);
      end
      check(skips == d, "R2 window skip count", skips, d);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(pulse_en == 1'b1, "R1 pulse_en in reset", int'(pulse_en), 1);
      check(throt_active == 1'b0, "R1 throt_active in reset", int'(throt_active), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int w = 0; w <= NCFG; w++) run_window(w);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end
endmodule